// File: doc/BRIEF.md
# Split-Phase Register File

A 32-entry, 32-bit register file for a pipelined processor, with two combinational read ports and one write port. Each read port shows the contents of its addressed register at all times. No clock edge is involved in a read.

In the default split-phase mode, the write port captures on the falling clock edge. This means the write completes in the first half of the cycle. A read of the same register later in that cycle therefore returns the new data. A writeback stage and a decode stage can then share a cycle without a hazard.

An elaboration-time parameter selects rising-edge capture instead. In that mode, a same-cycle read returns the previous contents, and the new value appears one cycle later. Register 0 is hardwired to zero. An active-low asynchronous reset clears every register.

Top module: `split_phase_regfile`

## Requirements
- R1: The file holds 32 registers of 32 bits. Two read ports address registers independently and can show two different registers at the same time.
- R2: Reads are combinational. When `raddr_a_i` or `raddr_b_i` changes, the matching output follows within the same clock phase, with no clock edge.
- R3: With `WR_EDGE = EDGE_FALL` (the default), a write is captured on the falling edge of `clk_i`. A read of the written register in the same cycle, sampled after that falling edge, returns the new data.
- R4: Reading address 0 returns zero on both ports. A write to address 0 is discarded.
- R5: While `we_i` is low, no register changes, whatever `waddr_i` and `wdata_i` carry.
- R6: Driving `rst_ni` low clears every register to zero at once, without waiting for a clock edge.
- R7: With `WR_EDGE = EDGE_RISE`, a write is captured on the rising edge of `clk_i`. A read in the cycle of the write returns the old contents. The new data is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the active edge is set by `WR_EDGE` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Write address |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Read address, port A |
| rdata_a_o | output | 32 | Read data, port A |
| raddr_b_i | input | 5 | Read address, port B |
| rdata_b_o | output | 32 | Read data, port B |

## Verification
The assertions assume that `we_i`, `waddr_i`, `wdata_i` and the read addresses change only just after a rising edge. They must then stay steady until the next rising edge, so that a falling-edge write and the end-of-cycle sample see the same values. The same-cycle-visibility property is also only armed once a falling edge has passed outside reset. The bench drives all inputs one nanosecond after each rising edge and samples one nanosecond after the falling edge. It keeps the write enable low around every reset pulse. The only mid-cycle input changes are read-address changes, which test combinational reads, and no write is pending while they happen.

// File: rtl/split_rf_pkg.sv
package split_rf_pkg;
  localparam int RF_DEPTH  = 32;
  localparam int RF_DATA_W = 32;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } wr_edge_e;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  output logic [NUM_REGS-1:0] wen_o
);
  // entry 0 is hardwired, never enabled
  assign wen_o[0] = 1'b0;
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_dec
    assign wen_o[g] = we_i && (waddr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import split_rf_pkg::*;
#(
  parameter int       NUM_REGS = 32,
  parameter int       DATA_W   = 32,
  parameter wr_edge_e WR_EDGE  = EDGE_FALL
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              wen_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  assign regs_o[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    if (WR_EDGE == EDGE_FALL) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (wen_i[g]) q <= wdata_i;
      end
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (wen_i[g]) q <= wdata_i;
      end
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]               raddr_i,
  output logic [DATA_W-1:0]               rdata_o
);
  // explicit compare mux: safe for non-power-of-two depths
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr_i == ADDR_W'(i)) rdata_o = regs_i[i];
    end
  end
endmodule

// File: rtl/split_phase_regfile.sv
module split_phase_regfile
  import split_rf_pkg::*;
#(
  parameter int       NUM_REGS = RF_DEPTH,
  parameter int       DATA_W   = RF_DATA_W,
  parameter wr_edge_e WR_EDGE  = EDGE_FALL,
  localparam int      ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [NUM_REGS-1:0]             wen;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  rf_wr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wen_o   (wen)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .WR_EDGE(WR_EDGE)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wen_i   (wen),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .regs_i  (regs),
    .raddr_i (raddr_a_i),
    .rdata_o (rdata_a_o)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .regs_i  (regs),
    .raddr_i (raddr_b_i),
    .rdata_o (rdata_b_o)
  );

  // ---------------- assertions ----------------
  p_zero_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));

  p_zero_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_rst_clear_r6: assert (rdata_a_o == '0 && rdata_b_o == '0);
    end
  end

  if (WR_EDGE == EDGE_FALL) begin : g_chk_fall
    // armed once a falling edge has passed out of reset
    logic armed_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed_q <= 1'b0;
      else         armed_q <= 1'b1;
    end

    p_same_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && we_i && waddr_i != '0 && raddr_a_i == waddr_i)
        |-> (rdata_a_o == wdata_i));
  end else begin : g_chk_rise
    p_next_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && waddr_i != '0)
        |=> (raddr_a_i != $past(waddr_i) || rdata_a_o == $past(wdata_i)));
  end
endmodule

// File: tb/split_phase_regfile_tb.sv
`timescale 1ns/1ps
module split_phase_regfile_tb;
  import split_rf_pkg::*;

  typedef struct packed {
    logic        we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
  } vec_t;

  // one cycle per entry, sampled after the falling edge (split-phase DUT)
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'd1,  32'h1111_1111, 5'd1,  5'd0,  32'h1111_1111, 32'h0},           // R3 R4
    '{1'b1, 5'd2,  32'h2222_2222, 5'd1,  5'd2,  32'h1111_1111, 32'h2222_2222},   // R1 R3
    '{1'b0, 5'd1,  32'hDEAD_BEEF, 5'd1,  5'd2,  32'h1111_1111, 32'h2222_2222},   // R5
    '{1'b1, 5'd0,  32'hCAFE_F00D, 5'd0,  5'd0,  32'h0,         32'h0},           // R4
    '{1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd1,  32'h8000_0001, 32'h1111_1111},   // R1 R3
    '{1'b1, 5'd1,  32'h0000_ABCD, 5'd1,  5'd31, 32'h0000_ABCD, 32'h8000_0001},   // R3
    '{1'b0, 5'd0,  32'h0,         5'd2,  5'd1,  32'h2222_2222, 32'h0000_ABCD},   // R5
    '{1'b1, 5'd30, 32'hFFFF_FFFF, 5'd31, 5'd30, 32'h8000_0001, 32'hFFFF_FFFF}    // R1 R3
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        we = 1'b0;
  logic [4:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  ra = '0;
  logic [4:0]  rb = '0;
  logic [31:0] rda, rdb, rise_a, rise_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  split_phase_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .rdata_a_o(rda), .raddr_b_i(rb), .rdata_b_o(rdb)
  );

  split_phase_regfile #(.WR_EDGE(EDGE_RISE)) u_dut_rise (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .rdata_a_o(rise_a), .raddr_b_i(rb), .rdata_b_o(rise_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    ra = 5'd5; rb = 5'd17;
    #1;
    check("R6 reset port A", rda, 32'h0);
    check("R6 reset port B", rdb, 32'h0);
    check("R6 reset rise A", rise_a, 32'h0);

    // vector table: R1 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk); #1;
      we = VECS[i].we; waddr = VECS[i].waddr; wdata = VECS[i].wdata;
      ra = VECS[i].ra; rb = VECS[i].rb;
      @(negedge clk); #1;
      check($sformatf("R1/R3/R4/R5 vec %0d port A", i), rda, VECS[i].exp_a);
      check($sformatf("R1/R3/R4/R5 vec %0d port B", i), rdb, VECS[i].exp_b);
    end

    // R7 rising mode old-then-new; R3 split-phase new at once
    @(posedge clk); #1;
    we = 1'b1; waddr = 5'd5; wdata = 32'h55AA_55AA; ra = 5'd5; rb = 5'd0;
    @(negedge clk); #1;
    check("R7 same-cycle old value", rise_a, 32'h0);
    check("R3 same-cycle new value", rda, 32'h55AA_55AA);
    @(posedge clk); #1;
    we = 1'b0;
    check("R7 next-cycle new value", rise_a, 32'h55AA_55AA);

    // R2 combinational read, no clock edge in between
    #0.2 ra = 5'd2;
    #0.3 check("R2 addr change A", rda, 32'h2222_2222);
    rb = 5'd31;
    #0.3 check("R2 addr change B", rdb, 32'h8000_0001);

    // R6 asynchronous reset mid-run
    @(posedge clk); #1;
    ra = 5'd31; rb = 5'd30;
    #0.5 rst_ni = 1'b0;
    #0.5;
    check("R6 async clear A", rda, 32'h0);
    check("R6 async clear rise", rise_b, 32'h0);
    @(posedge clk); #1 rst_ni = 1'b1;
    ra = 5'd1; rb = 5'd5;
    @(negedge clk); #1;
    check("R6 cleared reg1", rda, 32'h0);
    check("R6 cleared reg5", rise_b, 32'h0);

    // R4 write to zero ignored in rising mode too
    @(posedge clk); #1;
    we = 1'b1; waddr = 5'd0; wdata = 32'h1234_5678; ra = 5'd0;
    @(posedge clk); #1;
    we = 1'b0;
    check("R4 rise reg0 stays zero", rise_a, 32'h0);

    @(posedge clk); #1;
    summary();
  end
endmodule